// File: doc/BRIEF.md
# Dual-Output Interrupt Aggregator

This block collects a wide set of interrupt request lines and folds them onto two parent interrupt outputs. Every source carries its own configuration: edge or level detection, active sense, a steering bit that picks one of the two outputs, and an enable. Raw request lines are asynchronous to the block clock. Each passes through a two-stage synchroniser before any detection takes place. Edge-detected sources latch their event until software acknowledges them. Level sources report their input directly.

Software reaches the block through a word-addressed register bus split into two regions. The configuration region holds the per-source control arrays. The status region holds the acknowledge array, one masked pending array per output, and a summary word that shows which 32-source groups have work pending on each output. A handler reads the summary first, then the status word of the group it flagged, then acknowledges the source.

Top module: `irqAggTop`

## Requirements
- R1: Region 0 (busRegion=0) holds four arrays of GROUPS words each: type at word indices 0..G-1, polarity at G..2G-1, steering at 2G..3G-1, enable at 3G..4G-1. G is 7 by default. Source n is bit n%32 of word n/32 in each array, and every word reads back the value last written to it.
- R2: Region 1 (busRegion=1) holds the acknowledge array at word indices 0..G-1, the masked status of output 1 at G..2G-1, the masked status of output 0 at 2G..3G-1, and the summary word at word index 31 (byte offset 124).
- R3: With type bit 1 a source is edge detected and stays pending after its input returns idle. With type bit 0 it is level detected and is pending only while its input is active.
- R4: With polarity bit 0 a source is active high or rising edge. With polarity bit 1 it is active low or falling edge.
- R5: A steering bit of 1 sends a pending, enabled source to irqOut0, and 0 sends it to irqOut1. Each output is the OR of the masked status bits routed to it.
- R6: An enable bit of 0 blocks a source from status and from both outputs. An enable bit of 1 passes it.
- R7: Writing 1 to an acknowledge bit clears that source's latched edge, and writing 0 leaves it latched. A level source whose input is still active stays pending after an acknowledge write.
- R8: If a new edge is detected in the same cycle as an acknowledge write to that source, the edge stays latched.
- R9: In the summary word, bit g (0..6) is set when group g has masked pending sources routed to output 1. Bit 8+g is set for the same condition on output 0. All other bits read 0.
- R10: After reset all enable bits are 0, all type bits 1, all polarity bits 0, all steering bits 1, and no edge is latched. Both outputs are low.
- R11: Read data and rdValid appear one cycle after busRd. Reading the acknowledge array or any unmapped word returns 0.
- R12: A level change on a request line reaches the outputs after two rising clock edges, through the synchroniser, and not after one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| irqIn | input | NUM_SRC | Raw interrupt request lines |
| busRegion | input | 1 | Register region select (0 configuration, 1 status) |
| busAddr | input | ADDR_W | Word index within the region |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busWrData | input | 32 | Write data |
| rdData | output | 32 | Read data, valid with rdValid |
| rdValid | output | 1 | Read data valid, one cycle after busRd |
| irqOut0 | output | 1 | Parent interrupt output 0 |
| irqOut1 | output | 1 | Parent interrupt output 1 |

## Verification
The bench builds the block with its default parameters: 224 sources in seven full groups, a 5-bit word index, and output-0 summary flags starting at bit 8. With these values the bench can exercise sources in the first, a middle and the last group, and both summary fields show up in one read. Array boundaries at word indices 6/7, 13/14 and 20/21 are all decoded, and the summary word sits at the top of the index range. The bench schedules an acknowledge write so that it lands in the same cycle as a new detected edge. It also samples the outputs after one and after two clock edges to pin down the synchroniser latency.

// File: rtl/irqAggPkg.sv
package irqAggPkg;

  localparam int STRB_IDX_W = 8;

  typedef enum logic [3:0] {
    ARR_NONE,
    ARR_TYPE,
    ARR_POL,
    ARR_STEER,
    ARR_EN,
    ARR_ACK,
    ARR_STAT1,
    ARR_STAT0,
    ARR_SUM
  } arrSel_e;

  typedef struct packed {
    logic                  wrEn;
    logic                  rdEn;
    arrSel_e               arr;
    logic [STRB_IDX_W-1:0] idx;
  } ctrlStrb_t;

endpackage

// File: rtl/irqAggCtrl.sv
module irqAggCtrl
  import irqAggPkg::*;
#(
  parameter int GROUPS   = 7,
  parameter int ADDR_W   = 5,
  parameter int SUM_ADDR = 31
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busRegion,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  output ctrlStrb_t         strb,
  output logic              rdValid
);

  localparam int BASE1 = GROUPS;
  localparam int BASE2 = 2 * GROUPS;
  localparam int BASE3 = 3 * GROUPS;
  localparam int BASE4 = 4 * GROUPS;

  arrSel_e arrSel;
  int      wordIdx;
  int      baseIdx;

  always_comb begin
    wordIdx = int'(busAddr);
    arrSel  = ARR_NONE;
    baseIdx = 0;
    if (!busRegion) begin
      if (wordIdx < BASE1) begin
        arrSel = ARR_TYPE;
      end else if (wordIdx < BASE2) begin
        arrSel = ARR_POL;   baseIdx = BASE1;
      end else if (wordIdx < BASE3) begin
        arrSel = ARR_STEER; baseIdx = BASE2;
      end else if (wordIdx < BASE4) begin
        arrSel = ARR_EN;    baseIdx = BASE3;
      end
    end else begin
      if (wordIdx < BASE1) begin
        arrSel = ARR_ACK;
      end else if (wordIdx < BASE2) begin
        arrSel = ARR_STAT1; baseIdx = BASE1;
      end else if (wordIdx < BASE3) begin
        arrSel = ARR_STAT0; baseIdx = BASE2;
      end else if (wordIdx == SUM_ADDR) begin
        arrSel = ARR_SUM;
      end
    end
  end

  always_comb begin
    strb.wrEn = busWr;
    strb.rdEn = busRd;
    strb.arr  = arrSel;
    strb.idx  = STRB_IDX_W'(wordIdx - baseIdx);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdValid <= 1'b0;
    else       rdValid <= busRd;
  end

endmodule

// File: rtl/irqAggDatapath.sv
module irqAggDatapath
  import irqAggPkg::*;
#(
  parameter int NUM_SRC        = 224,
  parameter int GROUPS         = 7,
  parameter int SUM_OUT0_SHIFT = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqIn,
  input  ctrlStrb_t          strb,
  input  logic [31:0]        wrData,
  output logic [31:0]        rdData,
  output logic               irqOut0,
  output logic               irqOut1
);

  localparam int PADW = GROUPS * 32;

  logic [31:0] typeW  [GROUPS];
  logic [31:0] polW   [GROUPS];
  logic [31:0] steerW [GROUPS];
  logic [31:0] enW    [GROUPS];

  logic [PADW-1:0] rawPad, syncA, syncB, prevAct, edgeLat;
  logic [PADW-1:0] typeV, polV, steerV, enV, ackV;
  logic [PADW-1:0] actV, edgeDet, pendV, stat0V, stat1V;
  logic [GROUPS-1:0] grp0, grp1;
  logic [31:0] sumWord, rdNext;

  assign rawPad = PADW'(irqIn);

  // two-flop synchroniser and edge history
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA   <= '0;
      syncB   <= '0;
      prevAct <= '0;
    end else begin
      syncA   <= rawPad;
      syncB   <= syncA;
      prevAct <= actV;
    end
  end

  // per-group configuration words
  for (genvar g = 0; g < GROUPS; g++) begin : gCfg
    logic hitWr;
    assign hitWr = strb.wrEn && (strb.idx == STRB_IDX_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        typeW[g]  <= '1;
        polW[g]   <= '0;
        steerW[g] <= '1;
        enW[g]    <= '0;
      end else if (hitWr) begin
        case (strb.arr)
          ARR_TYPE:  typeW[g]  <= wrData;
          ARR_POL:   polW[g]   <= wrData;
          ARR_STEER: steerW[g] <= wrData;
          ARR_EN:    enW[g]    <= wrData;
          default: ;
        endcase
      end
    end

    assign typeV [g*32 +: 32] = typeW[g];
    assign polV  [g*32 +: 32] = polW[g];
    assign steerV[g*32 +: 32] = steerW[g];
    assign enV   [g*32 +: 32] = enW[g];
    assign ackV  [g*32 +: 32] = (hitWr && strb.arr == ARR_ACK) ? wrData : '0;

    assign grp0[g] = |stat0V[g*32 +: 32];
    assign grp1[g] = |stat1V[g*32 +: 32];
  end

  // detection: polarity folds falling/low into rising/high
  assign actV    = syncB ^ polV;
  assign edgeDet = actV & ~prevAct & typeV;

  // a fresh edge in the acknowledge cycle survives
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) edgeLat <= '0;
    else       edgeLat <= (edgeLat & ~ackV) | edgeDet;
  end

  assign pendV  = (typeV & edgeLat) | (~typeV & actV);
  assign stat0V = pendV & enV & steerV;
  assign stat1V = pendV & enV & ~steerV;

  assign irqOut0 = |stat0V;
  assign irqOut1 = |stat1V;

  always_comb begin
    sumWord = '0;
    sumWord[GROUPS-1:0]               = grp1;
    sumWord[SUM_OUT0_SHIFT +: GROUPS] = grp0;
  end

  always_comb begin
    rdNext = '0;
    if (strb.arr == ARR_SUM) rdNext = sumWord;
    for (int g = 0; g < GROUPS; g++) begin
      if (strb.idx == STRB_IDX_W'(g)) begin
        case (strb.arr)
          ARR_TYPE:  rdNext = typeW[g];
          ARR_POL:   rdNext = polW[g];
          ARR_STEER: rdNext = steerW[g];
          ARR_EN:    rdNext = enW[g];
          ARR_STAT1: rdNext = stat1V[g*32 +: 32];
          ARR_STAT0: rdNext = stat0V[g*32 +: 32];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          rdData <= '0;
    else if (strb.rdEn) rdData <= rdNext;
    else                rdData <= '0;
  end

endmodule

// File: rtl/irqAggTop.sv
module irqAggTop
  import irqAggPkg::*;
#(
  parameter int NUM_SRC        = 224,
  parameter int ADDR_W         = 5,
  parameter int SUM_ADDR       = 31,
  parameter int SUM_OUT0_SHIFT = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqIn,
  input  logic               busRegion,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWr,
  input  logic               busRd,
  input  logic [31:0]        busWrData,
  output logic [31:0]        rdData,
  output logic               rdValid,
  output logic               irqOut0,
  output logic               irqOut1
);

  localparam int GROUPS = (NUM_SRC + 31) / 32;

  ctrlStrb_t strb;

  irqAggCtrl #(
    .GROUPS(GROUPS), .ADDR_W(ADDR_W), .SUM_ADDR(SUM_ADDR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .busRegion(busRegion), .busAddr(busAddr),
    .busWr(busWr), .busRd(busRd),
    .strb(strb), .rdValid(rdValid)
  );

  irqAggDatapath #(
    .NUM_SRC(NUM_SRC), .GROUPS(GROUPS), .SUM_OUT0_SHIFT(SUM_OUT0_SHIFT)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .irqIn(irqIn), .strb(strb), .wrData(busWrData),
    .rdData(rdData), .irqOut0(irqOut0), .irqOut1(irqOut1)
  );

endmodule

// File: rtl/irqAggChecker.sv
module irqAggChecker #(
  parameter int GROUPS         = 7,
  parameter int ADDR_W         = 5,
  parameter int SUM_ADDR       = 31,
  parameter int SUM_OUT0_SHIFT = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              busRegion,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWr,
  input logic              busRd,
  input logic [31:0]       busWrData,
  input logic [31:0]       rdData,
  input logic              rdValid,
  input logic              irqOut0,
  input logic              irqOut1
);

  localparam logic [31:0] SUM_LEGAL =
    32'((64'(1) << GROUPS) - 1) | (32'((64'(1) << GROUPS) - 1) << SUM_OUT0_SHIFT);

  logic enSeen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) enSeen <= 1'b0;
    else if (busWr && !busRegion && int'(busAddr) >= 3 * GROUPS &&
             int'(busAddr) < 4 * GROUPS && busWrData != '0)
      enSeen <= 1'b1;
  end

  assert_rd_latency_R11: assert property (@(posedge clk) disable iff (!rstN)
    busRd |=> rdValid);

  assert_rd_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    !busRd |=> !rdValid);

  assert_ack_reads_zero_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busRegion && int'(busAddr) < GROUPS) |=> rdData == '0);

  assert_sum_reserved_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busRegion && int'(busAddr) == SUM_ADDR) |=> (rdData & ~SUM_LEGAL) == '0);

  assert_quiet_until_enabled_R10: assert property (@(posedge clk) disable iff (!rstN)
    !enSeen |-> (!irqOut0 && !irqOut1));

endmodule

bind irqAggTop irqAggChecker #(
  .GROUPS(GROUPS), .ADDR_W(ADDR_W), .SUM_ADDR(SUM_ADDR), .SUM_OUT0_SHIFT(SUM_OUT0_SHIFT)
) u_checker (
  .clk(clk), .rstN(rstN), .busRegion(busRegion), .busAddr(busAddr),
  .busWr(busWr), .busRd(busRd), .busWrData(busWrData),
  .rdData(rdData), .rdValid(rdValid), .irqOut0(irqOut0), .irqOut1(irqOut1)
);

// File: tb/tb_irqAggTop.sv
module tb_irqAggTop;

  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 224;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [NSRC-1:0] irqIn = '0;
  logic            busRegion = 1'b0;
  logic [4:0]      busAddr = '0;
  logic            busWr = 1'b0;
  logic            busRd = 1'b0;
  logic [31:0]     busWrData = '0;
  logic [31:0]     rdData;
  logic            rdValid, irqOut0, irqOut1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] expQ[$];
  string       tagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  irqAggTop dut (
    .clk(clk), .rstN(rstN), .irqIn(irqIn),
    .busRegion(busRegion), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWrData(busWrData), .rdData(rdData), .rdValid(rdValid),
    .irqOut0(irqOut0), .irqOut1(irqOut1)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic reg1, input int addr, input logic [31:0] data);
    busRegion = reg1; busAddr = 5'(addr); busWrData = data; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic reg1, input int addr, input logic [31:0] exp, input string tag);
    expQ.push_back(exp); tagQ.push_back(tag);
    busRegion = reg1; busAddr = 5'(addr); busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops expected read words as the design returns them
  always @(negedge clk) begin
    if (rdValid) begin
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R11: unexpected rdValid, actual %h expected none", rdData);
      end else begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front(); t = tagQ.pop_front();
        check(t, rdData, e);
      end
    end
  end

  task automatic finishRun;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected completion");
      finishRun();
    end
  end

  initial begin
    settle(3);
    rstN = 1'b1;
    settle(2);

    // reset state
    check("R10 irqOut0 after reset", 32'(irqOut0), 0);
    check("R10 irqOut1 after reset", 32'(irqOut1), 0);
    busRead(0, 0,  32'hFFFF_FFFF, "R10 type reset");
    busRead(0, 10, 32'h0,         "R10 polarity reset");
    busRead(0, 20, 32'hFFFF_FFFF, "R10 steering reset");
    busRead(0, 21, 32'h0,         "R10 enable reset");
    busRead(1, 31, 32'h0,         "R10 summary reset");

    // acknowledge array and holes read zero
    busRead(1, 0,  32'h0, "R11 ack array reads zero");
    busRead(0, 29, 32'h0, "R11 unmapped region0");
    busRead(1, 25, 32'h0, "R11 unmapped region1");

    // configuration readback and array boundaries
    busWrite(0, 9, 32'hA5A5_0000);
    busWrite(0, 4, 32'h0F0F_0F0F);
    busRead(0, 9, 32'hA5A5_0000, "R1 polarity word2 readback");
    busRead(0, 4, 32'h0F0F_0F0F, "R1 type word4 readback");
    busRead(0, 8, 32'h0,         "R1 polarity word1 untouched");
    busWrite(0, 9, 32'h0);
    busWrite(0, 4, 32'hFFFF_FFFF);

    // source 40: rising edge, steered to output 0
    busWrite(0, 22, 32'h0000_0100);
    irqIn[40] = 1'b1; settle(1); irqIn[40] = 1'b0; settle(4);
    check("R3 edge latched irqOut0", 32'(irqOut0), 1);
    check("R5 steer=1 keeps irqOut1 low", 32'(irqOut1), 0);
    busRead(1, 15, 32'h0000_0100, "R2 status0 word1");
    busRead(1, 8,  32'h0,         "R2 status1 word1");
    busRead(1, 31, 32'h0000_0200, "R9 summary out0 group1");

    // acknowledge with 0 then with 1
    busWrite(1, 1, 32'h0);
    busRead(1, 15, 32'h0000_0100, "R7 ack write 0 keeps edge");
    busWrite(1, 1, 32'h0000_0100);
    settle(1);
    check("R7 ack clears edge irqOut0", 32'(irqOut0), 0);
    busRead(1, 31, 32'h0, "R7 summary empty after ack");

    // source 200: active-low level, steered to output 1
    irqIn[200] = 1'b1;
    busWrite(0, 6,  32'hFFFF_FEFF);
    busWrite(0, 13, 32'h0000_0100);
    busWrite(0, 20, 32'hFFFF_FEFF);
    busWrite(0, 27, 32'h0000_0100);
    settle(4);
    check("R4 active-low idle high not pending", 32'(irqOut1), 0);
    irqIn[200] = 1'b0; settle(4);
    check("R4 active-low asserted irqOut1", 32'(irqOut1), 1);
    check("R5 steer=0 keeps irqOut0 low", 32'(irqOut0), 0);
    busRead(1, 13, 32'h0000_0100, "R2 status1 word6");
    busRead(1, 31, 32'h0000_0040, "R9 summary out1 group6");
    busWrite(1, 6, 32'h0000_0100);
    settle(1);
    check("R7 level stays pending after ack", 32'(irqOut1), 1);
    irqIn[200] = 1'b1; settle(4);
    check("R3 level drops with input", 32'(irqOut1), 0);

    // source 210: level high, enable off first, then latency
    busWrite(0, 6,  32'hFFFB_FEFF);
    busWrite(0, 20, 32'hFFFB_FEFF);
    irqIn[210] = 1'b1; settle(4);
    check("R6 disabled source blocked", 32'(irqOut1), 0);
    busRead(1, 13, 32'h0, "R6 disabled source not in status");
    irqIn[210] = 1'b0; settle(4);
    busWrite(0, 27, 32'h0004_0100);
    irqIn[210] = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R12 not visible after one edge", 32'(irqOut1), 0);
    @(posedge clk); @(negedge clk);
    check("R12 visible after two edges", 32'(irqOut1), 1);
    irqIn[210] = 1'b0; settle(4);

    // source 5: rising edge with acknowledge landing on a new edge
    busWrite(0, 21, 32'h0000_0020);
    irqIn[5] = 1'b1; settle(1); irqIn[5] = 1'b0; settle(4);
    busRead(1, 14, 32'h0000_0020, "R3 source5 latched");
    irqIn[5] = 1'b1;
    settle(2);
    busWrite(1, 0, 32'h0000_0020);
    irqIn[5] = 1'b0;
    settle(3);
    busRead(1, 14, 32'h0000_0020, "R8 new edge beats ack");
    busWrite(1, 0, 32'h0000_0020);
    busRead(1, 14, 32'h0, "R7 plain ack clears source5");

    // both outputs at once
    irqIn[40] = 1'b1; settle(1); irqIn[40] = 1'b0;
    irqIn[210] = 1'b1; settle(4);
    busRead(1, 31, 32'h0000_0240, "R9 summary both fields");
    check("R5 irqOut0 with both", 32'(irqOut0), 1);
    check("R5 irqOut1 with both", 32'(irqOut1), 1);

    // re-steer source 40 to output 1
    busWrite(0, 15, 32'hFFFF_FEFF);
    settle(1);
    check("R5 re-steered irqOut0 low", 32'(irqOut0), 0);
    busRead(1, 8,  32'h0000_0100, "R5 re-steered in status1");
    busRead(1, 31, 32'h0000_0042, "R9 summary after re-steer");

    settle(3);
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R11: actual %0d reads outstanding expected 0", expQ.size());
    end
    done = 1'b1;
    finishRun();
  end

endmodule